// File: doc/BRIEF.md
# Block Address Translation Unit

This unit maps a 32-bit effective address onto a physical address by consulting a small set of block translation entries. Each entry is a pair of 32-bit words. The tag word carries the effective block index, a block-size mask and two privilege-valid flags. The map word carries the physical block index and a two-bit access code. Instruction fetches and data accesses each have their own bank of entries. The request's `req_fetch` input selects the bank.

A request is presented for one cycle with `req_valid`. In that cycle, every entry of the selected bank is compared with the address in parallel. The lowest-numbered entry that both matches and is valid for the current privilege wins. On the following clock edge the unit registers the hit flag, the denial flag, the granted rights and the translated address. Software loads entries one word at a time through a write port. An address that no entry covers reports a miss. The caller then falls back to another translation path, which lies outside this unit.

Top module: `blk_xlate_unit`

## Requirements
- R1: After reset every entry word is zero, `rsp_valid` is 0, and any request made before programming returns a miss.
- R2: An entry matches only when address bits [31:28] equal tag bits [31:28].
- R3: The tag bits [12:2] form an 11-bit mask over address bits [27:17]. Where a mask bit is 1, that address bit is not compared. Where it is 0, the address bit must equal the tag bit in the same position [27:17].
- R4: When `req_user`=0 an entry is usable only if tag bit 1 is set. When `req_user`=1 it is usable only if tag bit 0 is set. A matching entry that is not usable is skipped.
- R5: The access code is map bits [1:0]. `rsp_prot` is {read, write, execute}. Code 0 gives 3'b000, code 2 gives 3'b111, and codes 1 and 3 give 3'b101.
- R6: On a hit, `rsp_paddr` is {map[31:28], (addr[27:17] AND mask) OR map[27:17], addr[16:0]}.
- R7: When several entries are usable matches, the one with the lowest index is used.
- R8: A hit is denied (`rsp_deny`=1, `rsp_hit`=1) in two cases. One is when the code grants nothing. The other is a data write (`req_write`=1, `req_fetch`=0) to an entry without write permission. Fetches and reads to code 1 or 3 are allowed.
- R9: Fetches (`req_fetch`=1) use only the instruction bank. Data accesses use only the data bank. The write port picks the bank with `cfg_bank` (1 = instruction), the entry with `cfg_idx`, and the word with `cfg_tag` (1 = tag word, 0 = map word).
- R10: Results appear exactly one clock after a `req_valid` cycle, with `rsp_valid` high for that single cycle. Without a request the result outputs hold their values.
- R11: On a miss, `rsp_hit`, `rsp_deny`, `rsp_prot` and `rsp_paddr` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Entry word write strobe |
| cfg_bank | input | 1 | 1 = instruction bank, 0 = data bank |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_tag | input | 1 | 1 = tag word, 0 = map word |
| cfg_wdata | input | 32 | Word to write |
| req_valid | input | 1 | Translation request strobe |
| req_fetch | input | 1 | 1 = instruction fetch |
| req_write | input | 1 | 1 = data write |
| req_user | input | 1 | 1 = user privilege, 0 = supervisor |
| req_addr | input | 32 | Effective address |
| rsp_valid | output | 1 | Result strobe, one cycle after the request |
| rsp_hit | output | 1 | A usable entry matched |
| rsp_deny | output | 1 | Hit but access not permitted |
| rsp_prot | output | 3 | Granted rights {read, write, execute} |
| rsp_paddr | output | 32 | Physical address |

## Verification
On every cycle the assertions check several properties of the result path. They check the one-cycle request-to-result timing and that results hold between requests. They check that a denial always comes with a hit, and that a miss drives all result fields to zero. They check that the rights vector is one of the three legal values, that the low 17 address bits pass through on a hit, and that a write to a non-writable block is always denied. The rest can only be shown by the bench's sweeps, which compare every response against a model computed from the entry words the bench itself wrote. That covers the choice of entry: masked comparison, privilege-based skipping, lowest-index priority and bank separation. It also covers the exact merge of the physical block bits.

// File: rtl/bxu_pkg.sv
package bxu_pkg;
  localparam int WORD_W = 32;
  localparam int MSK_W  = 11;
  localparam int PROT_W = 3;

  typedef struct packed {
    logic              usable;
    logic [PROT_W-1:0] prot;
    logic [WORD_W-1:0] paddr;
  } ent_res_t;

  function automatic logic [PROT_W-1:0] code_to_prot(input logic [1:0] code);
    case (code)
      2'd0:    code_to_prot = 3'b000;
      2'd2:    code_to_prot = 3'b111;
      default: code_to_prot = 3'b101;
    endcase
  endfunction
endpackage

// File: rtl/bxu_bank_store.sv
module bxu_bank_store import bxu_pkg::*; #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cfg_we,
  input  logic                            cfg_bank,
  input  logic [IDX_W-1:0]                cfg_idx,
  input  logic                            cfg_tag,
  input  logic [WORD_W-1:0]               cfg_wdata,
  output logic [1:0][ENTRIES-1:0][WORD_W-1:0] tag_q,
  output logic [1:0][ENTRIES-1:0][WORD_W-1:0] map_q
);
  for (genvar b = 0; b < 2; b++) begin : g_bank
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic tag_en, map_en;
      always_comb begin
        tag_en = cfg_we && (cfg_bank == b[0]) && (cfg_idx == e[IDX_W-1:0]) && cfg_tag;
        map_en = cfg_we && (cfg_bank == b[0]) && (cfg_idx == e[IDX_W-1:0]) && !cfg_tag;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          tag_q[b][e] <= '0;
          map_q[b][e] <= '0;
        end else begin
          if (tag_en) tag_q[b][e] <= cfg_wdata;
          if (map_en) map_q[b][e] <= cfg_wdata;
        end
      end
    end
  end
endmodule

// File: rtl/bxu_entry_cmp.sv
module bxu_entry_cmp import bxu_pkg::*; (
  input  logic [WORD_W-1:0] tag_w,
  input  logic [WORD_W-1:0] map_w,
  input  logic [WORD_W-1:0] addr,
  input  logic              user,
  output ent_res_t          res
);
  logic [MSK_W-1:0] blk_mask;
  logic             hi_eq, mid_eq, priv_ok;
  logic             unused_bits;

  always_comb begin
    blk_mask = tag_w[12:2];
    hi_eq    = (addr[31:28] == tag_w[31:28]);
    mid_eq   = ((addr[27:17] & ~blk_mask) == tag_w[27:17]);
    priv_ok  = user ? tag_w[0] : tag_w[1];
    res.usable = hi_eq && mid_eq && priv_ok;
    res.prot   = code_to_prot(map_w[1:0]);
    res.paddr  = {map_w[31:28], (addr[27:17] & blk_mask) | map_w[27:17], addr[16:0]};
  end

  assign unused_bits = ^{tag_w[16:13], map_w[16:2]};
endmodule

// File: rtl/bxu_pick.sv
module bxu_pick import bxu_pkg::*; #(
  parameter int ENTRIES = 4
) (
  input  ent_res_t [ENTRIES-1:0] cand,
  input  logic                   is_write,
  input  logic                   is_fetch,
  output logic                   hit,
  output logic                   deny,
  output logic [PROT_W-1:0]      prot,
  output logic [WORD_W-1:0]      paddr
);
  always_comb begin
    hit   = 1'b0;
    prot  = '0;
    paddr = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (cand[i].usable) begin
        hit   = 1'b1;
        prot  = cand[i].prot;
        paddr = cand[i].paddr;
      end
    end
    deny = hit && ((prot == 3'b000) || (is_write && !is_fetch && !prot[1]));
  end
endmodule

// File: rtl/blk_xlate_unit.sv
module blk_xlate_unit import bxu_pkg::*; #(
  parameter int ENTRIES = 4,
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic               cfg_bank,
  input  logic [IDX_W-1:0]   cfg_idx,
  input  logic               cfg_tag,
  input  logic [31:0]        cfg_wdata,
  input  logic               req_valid,
  input  logic               req_fetch,
  input  logic               req_write,
  input  logic               req_user,
  input  logic [31:0]        req_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_deny,
  output logic [2:0]         rsp_prot,
  output logic [31:0]        rsp_paddr
);
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [1:0][ENTRIES-1:0][WORD_W-1:0] tag_q, map_q;

  bxu_bank_store #(.ENTRIES(ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank),
    .cfg_idx(cfg_idx), .cfg_tag(cfg_tag), .cfg_wdata(cfg_wdata),
    .tag_q(tag_q), .map_q(map_q)
  );

  ent_res_t [ENTRIES-1:0] cand;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    bxu_entry_cmp u_cmp (
      .tag_w(tag_q[req_fetch][e]), .map_w(map_q[req_fetch][e]),
      .addr(req_addr), .user(req_user), .res(cand[e])
    );
  end

  logic              hit_d, deny_d;
  logic [PROT_W-1:0] prot_d;
  logic [WORD_W-1:0] paddr_d;

  bxu_pick #(.ENTRIES(ENTRIES)) u_pick (
    .cand(cand), .is_write(req_write), .is_fetch(req_fetch),
    .hit(hit_d), .deny(deny_d), .prot(prot_d), .paddr(paddr_d)
  );

  logic              res_en;
  logic              vld_n, hit_n, deny_n;
  logic [PROT_W-1:0] prot_n;
  logic [WORD_W-1:0] paddr_n;

  always_comb begin
    res_en  = req_valid;
    vld_n   = req_valid;
    hit_n   = res_en ? hit_d   : rsp_hit;
    deny_n  = res_en ? deny_d  : rsp_deny;
    prot_n  = res_en ? prot_d  : rsp_prot;
    paddr_n = res_en ? paddr_d : rsp_paddr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_deny  <= 1'b0;
      rsp_prot  <= '0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= vld_n;
      rsp_hit   <= hit_n;
      rsp_deny  <= deny_n;
      rsp_prot  <= prot_n;
      rsp_paddr <= paddr_n;
    end
  end
endmodule

// File: rtl/bxu_checker.sv
module bxu_checker (
  input logic        clk,
  input logic        rst_sync_n,
  input logic        req_valid,
  input logic        req_fetch,
  input logic        req_write,
  input logic [31:0] req_addr,
  input logic        rsp_valid,
  input logic        rsp_hit,
  input logic        rsp_deny,
  input logic [2:0]  rsp_prot,
  input logic [31:0] rsp_paddr
);
  a_r10_strobe_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> rsp_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> !rsp_valid);
  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !req_valid |=> ($stable(rsp_paddr) && $stable(rsp_hit) && $stable(rsp_deny) && $stable(rsp_prot)));
  a_r8_deny_needs_hit: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rsp_deny |-> rsp_hit);
  a_r11_miss_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_valid && !rsp_hit) |-> (rsp_paddr == 32'h0 && rsp_prot == 3'b000 && !rsp_deny));
  a_r5_legal_rights: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rsp_prot == 3'b000) || (rsp_prot == 3'b101) || (rsp_prot == 3'b111));
  a_r6_offset_through: assert property (@(posedge clk) disable iff (!rst_sync_n)
    req_valid |=> (!rsp_hit || rsp_paddr[16:0] == $past(req_addr[16:0])));
  a_r8_write_blocked: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && req_write && !req_fetch) |=> (!rsp_hit || rsp_prot[1] || rsp_deny));
endmodule

bind blk_xlate_unit bxu_checker u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .req_valid(req_valid), .req_fetch(req_fetch),
  .req_write(req_write), .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_deny(rsp_deny), .rsp_prot(rsp_prot), .rsp_paddr(rsp_paddr)
);

// File: tb/blk_xlate_unit_test.sv
`timescale 1ns/1ps
module blk_xlate_unit_test;
  localparam int N = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_bank, cfg_tag;
  logic [IW-1:0] cfg_idx;
  logic [31:0] cfg_wdata;
  logic req_valid, req_fetch, req_write, req_user;
  logic [31:0] req_addr;
  logic rsp_valid, rsp_hit, rsp_deny;
  logic [2:0] rsp_prot;
  logic [31:0] rsp_paddr;

  always #2 clk = ~clk;

  blk_xlate_unit #(.ENTRIES(N)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_idx(cfg_idx),
    .cfg_tag(cfg_tag), .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_fetch(req_fetch),
    .req_write(req_write), .req_user(req_user), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_deny(rsp_deny), .rsp_prot(rsp_prot), .rsp_paddr(rsp_paddr)
  );

  int n_run = 0;
  int n_bad = 0;
  bit finished = 0;
  logic [31:0] sh_tag [2][N];
  logic [31:0] sh_map [2][N];

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input bit bank, input int idx, input bit is_tag, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_bank = bank; cfg_idx = idx[IW-1:0]; cfg_tag = is_tag; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    if (is_tag) sh_tag[bank][idx] = d; else sh_map[bank][idx] = d;
  endtask

  // Expected result from the requirement text: {hit, deny, prot, paddr}
  function automatic logic [36:0] model(input logic [31:0] a, input bit usr, input bit w, input bit f);
    logic [10:0] m;
    logic [2:0] p;
    for (int i = 0; i < N; i++) begin
      m = sh_tag[f][i][12:2];
      if (a[31:28] == sh_tag[f][i][31:28] && (a[27:17] & ~m) == sh_tag[f][i][27:17]
          && (usr ? sh_tag[f][i][0] : sh_tag[f][i][1])) begin
        p = (sh_map[f][i][1:0] == 2'd0) ? 3'b000 : (sh_map[f][i][1:0] == 2'd2) ? 3'b111 : 3'b101;
        return {1'b1, (p == 3'b000) || (w && !f && !p[1]), p,
                sh_map[f][i][31:28], (a[27:17] & m) | sh_map[f][i][27:17], a[16:0]};
      end
    end
    return '0;
  endfunction

  task automatic req(input logic [31:0] a, input bit usr, input bit w, input bit f, input string tag);
    logic [36:0] e;
    e = model(a, usr, w, f);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_user = usr; req_write = w; req_fetch = f;
    @(negedge clk);
    req_valid = 0;
    chk({tag, " R10 strobe"}, {63'd0, rsp_valid}, 64'd1);
    if (!e[36]) chk({tag, " R11 miss"}, {27'd0, rsp_hit, rsp_deny, rsp_prot, rsp_paddr}, {27'd0, e});
    else begin
      chk({tag, " R8 hit/deny"}, {62'd0, rsp_hit, rsp_deny}, {62'd0, e[36:35]});
      chk({tag, " R5 rights"}, {61'd0, rsp_prot}, {61'd0, e[34:32]});
      chk({tag, " R6 paddr"}, {32'd0, rsp_paddr}, {32'd0, e[31:0]});
    end
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    logic [10:0] mids [8];
    mids = '{11'h000, 11'h7FF, 11'h0F0, 11'h0F5, 11'h155, 11'h2AA, 11'h001, 11'h010};
    for (int b = 0; b < 2; b++) for (int i = 0; i < N; i++) begin
      sh_tag[b][i] = 0; sh_map[b][i] = 0;
    end
    rst_n = 0; cfg_we = 0; cfg_bank = 0; cfg_idx = 0; cfg_tag = 0; cfg_wdata = 0;
    req_valid = 0; req_fetch = 0; req_write = 0; req_user = 0; req_addr = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {63'd0, rsp_valid}, 64'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset", {31'd0, rsp_hit, rsp_paddr}, 64'd0);
    req(32'h0000_0000, 0, 0, 0, "R1 unprogrammed");
    req(32'h1234_5678, 1, 1, 1, "R1 unprogrammed fetch");

    // data bank
    wr(0, 0, 1, 32'h1000_0001); wr(0, 0, 0, 32'h8000_0002);   // user only, 128KB, rwx
    wr(0, 1, 1, 32'h1000_1FFF); wr(0, 1, 0, 32'h9020_0001);   // both, 256MB, rx
    wr(0, 2, 1, 32'h51E0_003E); wr(0, 2, 0, 32'hA000_0003);   // supervisor, partial mask
    wr(0, 3, 1, 32'h3000_0003); wr(0, 3, 0, 32'h4000_0000);   // no access
    // instruction bank
    wr(1, 0, 1, 32'h2000_1FFE); wr(1, 0, 0, 32'hC000_0003);
    wr(1, 1, 1, 32'h1000_0003); wr(1, 1, 0, 32'hE000_0002);

    req(32'h1000_1234, 1, 0, 0, "R7 lowest index wins");
    chk("R7 entry0 block", {32'd0, rsp_paddr}, {32'd0, 32'h8000_1234});
    req(32'h1000_1234, 0, 0, 0, "R4 supervisor skips user-only");
    chk("R4 falls to entry1", {32'd0, rsp_paddr}, {32'd0, 32'h9020_1234});
    req(32'h1000_1234, 0, 1, 0, "R8 write to rx block");
    chk("R8 denied write", {62'd0, rsp_hit, rsp_deny}, 64'd3);
    req(32'h3000_0000, 0, 0, 0, "R8 code zero");
    chk("R8 code zero denied", {62'd0, rsp_hit, rsp_deny}, 64'd3);
    req(32'h51E0_0000, 1, 0, 0, "R4 user on supervisor entry");
    chk("R4 user miss", {63'd0, rsp_hit}, 64'd0);
    req(32'h1000_0000, 0, 0, 1, "R9 fetch uses instruction bank");
    chk("R9 instr entry1", {32'd0, rsp_paddr}, {32'd0, 32'hE000_0000});
    req(32'h2FFF_FFFF, 0, 0, 0, "R9 data bank lacks instr entry");
    chk("R9 data miss", {63'd0, rsp_hit}, 64'd0);
    req(32'h1002_0000, 1, 0, 0, "R3 unmasked bit differs");
    chk("R3 entry0 skipped", {32'd0, rsp_paddr}, {32'd0, 32'h9022_0000});
    req(32'h0000_0000, 0, 0, 0, "R2 nibble mismatch");

    // R10: hold while idle
    req(32'h1ABC_DEF0, 0, 0, 0, "R10 setup");
    held = rsp_paddr;
    repeat (3) begin
      @(negedge clk);
      chk("R10 idle strobe low", {63'd0, rsp_valid}, 64'd0);
      chk("R10 result held", {32'd0, rsp_paddr}, {32'd0, held});
    end

    // sweep: top nibble, middle pattern, privilege, write, fetch
    for (int t = 0; t < 16; t++)
      for (int m = 0; m < 8; m++)
        for (int k = 0; k < 8; k++)
          req({t[3:0], mids[m], 17'h0A5C3 ^ {k[2:0], 14'h0}}, k[0], k[1], k[2], "R2 R3 R4 R7 sweep");

    // rewrite and re-sweep a subset (R9 programming path)
    wr(0, 0, 1, 32'h1000_0000);
    wr(1, 2, 1, 32'h5000_1FFF); wr(1, 2, 0, 32'h6000_0001);
    for (int t = 0; t < 16; t++)
      for (int k = 0; k < 8; k++)
        req({t[3:0], mids[k], 17'h1F00F}, k[0], k[1], k[2], "R9 reprogrammed sweep");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule